// File: doc/BRIEF.md
# DMA bus-turnaround idle inserter

This block sits between a DMA engine and the external bus sequencer. It takes one access descriptor per cycle over a valid/ready handshake and issues a bus-cycle strobe for each accepted access. After an access to an external device selected by the DMA acknowledge in single-address mode, it holds off the next access for a programmed number of idle cycles. This gives the bus time to turn around between drivers. A method bit selects the rule. With the bit clear, the gap is added only when the data bus changes hands away from the acknowledged device. With the bit set, the gap follows every acknowledged single-address access.

The block also arbitrates refresh and bus-mastership requests against DMA bursts. A 2-bit priority field decides which request types may be granted while a burst is in progress. A request that is held off stays pending and is granted on the first idle bus cycle after the burst closes. If the reserved priority code is programmed, the block treats it as the strictest code and sets a sticky error flag.

Configuration is latched from the `cfg_*` inputs on `cfg_wr`. Reset is asynchronous active-low and is released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `dma_idle_inserter`

## Requirements
- R1: After reset, the configuration is all zero, `bus_strobe`, `bus_dack`, `ref_gnt`, `mst_gnt` and `prio_err` are low, and `acc_ready` is high for any valid descriptor.
- R2: The idle code maps 0→0, 1→1, 2→2, 3→4, 4→6, 5→8, 6→10 and 7→12 idle cycles. An idle cycle is a cycle with no accepted access between two accepted accesses.
- R3: With `cfg_idle_all`=0, a gap is owed only if the previous accepted access had `acc_dack`=1, `acc_single`=1 and `acc_ext_drv`=1, and the waiting descriptor has `acc_ext_drv`=0. If the waiting descriptor has `acc_ext_drv`=1, it is accepted with no gap.
- R4: With `cfg_idle_all`=1, every access that follows an accepted access with `acc_dack`=1 and `acc_single`=1 waits for the programmed idle count, whatever the drivers are.
- R5: An accepted access with `acc_dack`=0 or `acc_single`=0 owes no gap: the next valid descriptor sees `acc_ready`=1.
- R6: `bus_strobe` is high in the cycle after each accepted access and low otherwise. `bus_dack` is high in that same cycle exactly when the accepted access had `acc_dack`=1.
- R7: Priority code 00 grants both refresh and mastership requests during a burst. A burst is open after an accepted access with `acc_burst`=1 and `acc_last`=0, and it closes after an accepted access with `acc_burst`=0 or `acc_last`=1.
- R8: Priority code 01 grants refresh requests during a burst but holds mastership requests until the burst closes.
- R9: Priority code 10 holds both request types during a burst. Each held request is granted in the cycle after the first cycle with no accepted access once the burst has closed.
- R10: Priority code 11 behaves like code 10 and sets `prio_err` one cycle after it is latched. `prio_err` then stays high until reset.
- R11: A pulse on `ref_req` or `mst_req` makes the request pending until granted. Each grant is a one-cycle pulse one cycle after a cycle with no accepted access. Refresh wins when both are pending.
- R12: Configuration fields change only on a cycle with `cfg_wr`=1. The idle count is taken from the configuration in force when the access that owes the gap is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Latch the configuration inputs |
| cfg_idle_code | input | 3 | Idle count code |
| cfg_idle_all | input | 1 | Insertion method: 1 = after every acknowledged access |
| cfg_burst_prio | input | 2 | Request gating during bursts |
| acc_valid | input | 1 | Descriptor valid |
| acc_ready | output | 1 | Descriptor accepted this cycle when valid |
| acc_dack | input | 1 | Access targets the acknowledged external device |
| acc_ext_drv | input | 1 | Acknowledged device drives the data bus this access |
| acc_single | input | 1 | Single-address transfer mode |
| acc_burst | input | 1 | Access is part of a DMA burst |
| acc_last | input | 1 | Last access of the burst |
| ref_req | input | 1 | Refresh request pulse |
| mst_req | input | 1 | Bus-mastership request pulse |
| bus_strobe | output | 1 | Bus-cycle strobe |
| bus_dack | output | 1 | Acknowledge strobe for the issued cycle |
| ref_gnt | output | 1 | Refresh grant pulse |
| mst_gnt | output | 1 | Mastership grant pulse |
| prio_err | output | 1 | Sticky reserved-priority flag |

## Verification
`acc_ready` is combinational and is due in the same cycle as the descriptor, so the bench samples it one time step after driving inputs on the falling edge. `bus_strobe`, `bus_dack`, `ref_gnt` and `mst_gnt` are due one clock after the deciding cycle. `prio_err` is due one clock after the reserved code is latched. The bench compares these outputs on the falling edge after that clock. It does this against a cycle model that it advances with its own expected handshake result, not the design's. Gap lengths are measured directly, by counting the cycles a waiting descriptor sits with `acc_ready` low.

// File: rtl/dmai_pkg.sv
package dmai_pkg;
  localparam int IDLE_CODE_W = 3;
  localparam int MAX_IDLE    = 12;
  localparam int CNT_W       = $clog2(MAX_IDLE + 1);
  localparam int PRIO_W      = 2;

  typedef enum logic [PRIO_W-1:0] {
    PRIO_ALL      = 2'b00,
    PRIO_REF_ONLY = 2'b01,
    PRIO_NONE     = 2'b10,
    PRIO_RSVD     = 2'b11
  } prio_e;

  // codes 0..2 are literal, above that the count steps by two
  function automatic logic [CNT_W-1:0] idle_decode(input logic [IDLE_CODE_W-1:0] code);
    logic [CNT_W-1:0] cx;
    cx = CNT_W'(code);
    return (cx <= CNT_W'(2)) ? cx : CNT_W'((cx - CNT_W'(1)) << 1);
  endfunction
endpackage

// File: rtl/dmai_gap_ctl.sv
module dmai_gap_ctl
  import dmai_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             acc_dack,
  input  logic             acc_single,
  input  logic             acc_ext_drv,
  input  logic             idle_all,
  input  logic [CNT_W-1:0] idle_load,
  output logic             ready
);
  logic [CNT_W-1:0] left_q, left_d;
  logic             armed_q, armed_d;
  logic             extdrv_q, extdrv_d;
  logic             need_gap;

  always_comb begin
    left_d   = left_q;
    armed_d  = armed_q;
    extdrv_d = extdrv_q;
    if (accept) begin
      left_d   = idle_load;
      armed_d  = acc_dack & acc_single;
      extdrv_d = acc_ext_drv;
    end else if (left_q != '0) begin
      left_d = left_q - CNT_W'(1);
    end
  end

  assign need_gap = armed_q & (idle_all | (extdrv_q & ~acc_ext_drv));
  assign ready    = ~need_gap | (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      armed_q  <= 1'b0;
      extdrv_q <= 1'b0;
    end else begin
      left_q   <= left_d;
      armed_q  <= armed_d;
      extdrv_q <= extdrv_d;
    end
  end
endmodule

// File: rtl/dmai_req_gate.sv
module dmai_req_gate
  import dmai_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_req,
  input  logic  mst_req,
  input  logic  bus_busy,
  input  logic  burst_on,
  input  prio_e prio,
  output logic  ref_gnt,
  output logic  mst_gnt
);
  logic ref_pend_q, ref_pend_d, mst_pend_q, mst_pend_d;
  logic ref_gnt_q, mst_gnt_q;
  logic ref_ok, mst_ok, ref_now, mst_now;

  always_comb begin
    ref_ok     = ~burst_on | (prio == PRIO_ALL) | (prio == PRIO_REF_ONLY);
    mst_ok     = ~burst_on | (prio == PRIO_ALL);
    ref_now    = ref_pend_q & ref_ok & ~bus_busy;
    mst_now    = mst_pend_q & mst_ok & ~bus_busy & ~ref_now;
    ref_pend_d = (ref_pend_q & ~ref_now) | ref_req;
    mst_pend_d = (mst_pend_q & ~mst_now) | mst_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pend_q <= 1'b0;
      mst_pend_q <= 1'b0;
      ref_gnt_q  <= 1'b0;
      mst_gnt_q  <= 1'b0;
    end else begin
      ref_pend_q <= ref_pend_d;
      mst_pend_q <= mst_pend_d;
      ref_gnt_q  <= ref_now;
      mst_gnt_q  <= mst_now;
    end
  end

  assign ref_gnt = ref_gnt_q;
  assign mst_gnt = mst_gnt_q;
endmodule

// File: rtl/dma_idle_inserter.sv
module dma_idle_inserter
  import dmai_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [IDLE_CODE_W-1:0] cfg_idle_code,
  input  logic                   cfg_idle_all,
  input  logic [PRIO_W-1:0]      cfg_burst_prio,
  input  logic                   acc_valid,
  output logic                   acc_ready,
  input  logic                   acc_dack,
  input  logic                   acc_ext_drv,
  input  logic                   acc_single,
  input  logic                   acc_burst,
  input  logic                   acc_last,
  input  logic                   ref_req,
  input  logic                   mst_req,
  output logic                   bus_strobe,
  output logic                   bus_dack,
  output logic                   ref_gnt,
  output logic                   mst_gnt,
  output logic                   prio_err
);
  // reset synchronizer: asserts at once, releases on the second edge
  logic rs_q1, rs_q2, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_i = rs_q2;

  logic [IDLE_CODE_W-1:0] code_q, code_d;
  logic                   all_q, all_d;
  prio_e                  prio_q, prio_d, prio_eff;
  logic                   err_q, err_d;
  logic                   burst_q, burst_d;
  logic                   strobe_q, strobe_d, dack_q, dack_d;
  logic                   accept;
  logic                   gap_ready;

  assign accept    = acc_valid & gap_ready;
  assign acc_ready = gap_ready;
  assign prio_eff  = (prio_q == PRIO_RSVD) ? PRIO_NONE : prio_q;

  always_comb begin
    code_d   = code_q;
    all_d    = all_q;
    prio_d   = prio_q;
    if (cfg_wr) begin
      code_d = cfg_idle_code;
      all_d  = cfg_idle_all;
      prio_d = prio_e'(cfg_burst_prio);
    end
    err_d    = err_q | (prio_q == PRIO_RSVD);
    burst_d  = accept ? (acc_burst & ~acc_last) : burst_q;
    strobe_d = accept;
    dack_d   = accept & acc_dack;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      code_q   <= '0;
      all_q    <= 1'b0;
      prio_q   <= PRIO_ALL;
      err_q    <= 1'b0;
      burst_q  <= 1'b0;
      strobe_q <= 1'b0;
      dack_q   <= 1'b0;
    end else begin
      code_q   <= code_d;
      all_q    <= all_d;
      prio_q   <= prio_d;
      err_q    <= err_d;
      burst_q  <= burst_d;
      strobe_q <= strobe_d;
      dack_q   <= dack_d;
    end
  end

  dmai_gap_ctl i_gap (
    .clk        (clk),
    .rst_n      (rst_i),
    .accept     (accept),
    .acc_dack   (acc_dack),
    .acc_single (acc_single),
    .acc_ext_drv(acc_ext_drv),
    .idle_all   (all_q),
    .idle_load  (idle_decode(code_q)),
    .ready      (gap_ready)
  );

  dmai_req_gate i_gate (
    .clk     (clk),
    .rst_n   (rst_i),
    .ref_req (ref_req),
    .mst_req (mst_req),
    .bus_busy(accept),
    .burst_on(burst_q),
    .prio    (prio_eff),
    .ref_gnt (ref_gnt),
    .mst_gnt (mst_gnt)
  );

  assign bus_strobe = strobe_q;
  assign bus_dack   = dack_q;
  assign prio_err   = err_q;
endmodule

// File: rtl/dmai_checker.sv
module dmai_checker
  import dmai_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             acc_dack,
  input logic             acc_ready,
  input logic             bus_strobe,
  input logic             bus_dack,
  input logic             ref_gnt,
  input logic             mst_gnt,
  input logic             prio_err,
  input logic             burst_on,
  input logic [1:0]       prio,
  input logic             idle_all,
  input logic             gap_armed,
  input logic [CNT_W-1:0] gap_left
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!bus_strobe && !bus_dack && !ref_gnt && !mst_gnt && !prio_err)); // R1
  AST_GAP_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n) (gap_armed && idle_all && gap_left != '0) |-> !acc_ready); // R4
  AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept |=> bus_strobe); // R6
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !accept |=> !bus_strobe); // R6
  AST_DACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (accept && acc_dack) |=> bus_dack); // R6
  AST_MST_HELD_BURST: assert property (@(posedge clk) disable iff (!rst_n) (burst_on && prio != 2'b00) |=> !mst_gnt); // R8
  AST_REF_HELD_BURST: assert property (@(posedge clk) disable iff (!rst_n) (burst_on && prio[1]) |=> !ref_gnt); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) prio_err |=> prio_err); // R10
  AST_GNT_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n) accept |=> (!ref_gnt && !mst_gnt)); // R11
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $countones({ref_gnt, mst_gnt}) <= 1); // R11
endmodule

bind dma_idle_inserter dmai_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_i),
  .accept    (accept),
  .acc_dack  (acc_dack),
  .acc_ready (acc_ready),
  .bus_strobe(bus_strobe),
  .bus_dack  (bus_dack),
  .ref_gnt   (ref_gnt),
  .mst_gnt   (mst_gnt),
  .prio_err  (prio_err),
  .burst_on  (burst_q),
  .prio      (prio_q),
  .idle_all  (all_q),
  .gap_armed (i_gap.armed_q),
  .gap_left  (i_gap.left_q)
);

// File: tb/test_dma_idle_inserter.sv
module test_dma_idle_inserter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_idle_all = 0;
  logic [2:0] cfg_idle_code = 0;
  logic [1:0] cfg_burst_prio = 0;
  logic acc_valid = 0, acc_dack = 0, acc_ext_drv = 0, acc_single = 0, acc_burst = 0, acc_last = 0;
  logic ref_req = 0, mst_req = 0;
  logic acc_ready, bus_strobe, bus_dack, ref_gnt, mst_gnt, prio_err;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model state
  int  m_code, m_prio, m_left;
  bit  m_all, m_gack, m_gext, m_burst, m_rp, m_mp, m_err;
  bit  m_strobe, m_dack, m_rg, m_mg;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_idle_inserter i_dma_idle_inserter (.*);

  function automatic int dec_code(int c);
    case (c)
      0: return 0;  1: return 1;  2: return 2;  3: return 4;
      4: return 6;  5: return 8;  6: return 10; default: return 12;
    endcase
  endfunction

  function automatic bit exp_ready();
    bit need;
    need = m_gack && (m_all || (m_gext && !acc_ext_drv));
    return !need || m_left == 0;
  endfunction

  function automatic string prio_tag();
    int e;
    e = (m_prio == 3) ? 2 : m_prio;
    return (e == 0) ? "R7" : (e == 1) ? "R8" : "R9";
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_code = 0; m_prio = 0; m_left = 0; m_all = 0; m_gack = 0; m_gext = 0;
    m_burst = 0; m_rp = 0; m_mp = 0; m_err = 0;
    m_strobe = 0; m_dack = 0; m_rg = 0; m_mg = 0;
  endtask

  task automatic set_idle();
    cfg_wr = 0; acc_valid = 0; ref_req = 0; mst_req = 0;
  endtask

  // one clock: check ready now, advance model, check registered outputs
  task automatic step();
    bit er, acc, rnow, mnow, rok, mok;
    int ep;
    #1;
    er = exp_ready();
    if (acc_valid) chk(m_gack ? (m_all ? "R4" : "R3") : "R5", acc_ready, er);
    acc = acc_valid && er;
    ep  = (m_prio == 3) ? 2 : m_prio;
    rok = !m_burst || ep <= 1;
    mok = !m_burst || ep == 0;
    rnow = m_rp && rok && !acc;
    mnow = m_mp && mok && !acc && !rnow;
    m_err = m_err || (m_prio == 3);
    m_left = acc ? dec_code(m_code) : (m_left > 0 ? m_left - 1 : 0);
    if (acc) begin
      m_gack = acc_dack && acc_single;
      m_gext = acc_ext_drv;
      m_burst = acc_burst && !acc_last;
    end
    m_rp = (m_rp && !rnow) || ref_req;
    m_mp = (m_mp && !mnow) || mst_req;
    m_strobe = acc; m_dack = acc && acc_dack; m_rg = rnow; m_mg = mnow;
    if (cfg_wr) begin
      m_code = cfg_idle_code; m_all = cfg_idle_all; m_prio = cfg_burst_prio;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R6", bus_strobe, m_strobe);
    chk("R6", bus_dack, m_dack);
    chk(prio_tag(), ref_gnt, m_rg);
    chk("R11", mst_gnt, m_mg);
    chk("R10", prio_err, m_err);
  endtask

  task automatic do_reset();
    rst_n = 0;
    set_idle();
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_cfg(int code, bit all, int prio);
    set_idle();
    cfg_wr = 1; cfg_idle_code = 3'(code); cfg_idle_all = all; cfg_burst_prio = 2'(prio);
    step();
    cfg_wr = 0;
  endtask

  task automatic drive(bit dack, bit ext, bit single, bit burst, bit last);
    acc_valid = 1; acc_dack = dack; acc_ext_drv = ext; acc_single = single;
    acc_burst = burst; acc_last = last;
  endtask

  task automatic idle_cycles(int n);
    set_idle();
    for (int i = 0; i < n; i++) step();
  endtask

  // accept first descriptor, then count cycles the second waits
  task automatic measure(bit d1, bit e1, bit s1, bit e2, output int waited);
    idle_cycles(14);
    drive(d1, e1, s1, 0, 0);
    step();
    drive(1, e2, 1, 0, 0);
    waited = 0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (acc_ready) begin
        step();
        break;
      end
      waited++;
      step();
    end
    set_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1: watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int w;
    void'($urandom(32'd4711));
    model_clear();
    do_reset();

    // R1: reset state, ready for any descriptor
    chk("R1", bus_strobe, 0); chk("R1", ref_gnt, 0); chk("R1", mst_gnt, 0); chk("R1", prio_err, 0);
    drive(1, 1, 1, 0, 0);
    #1; chk("R1", acc_ready, 1);
    step();
    set_idle();

    // R12: latched on cfg_wr only
    write_cfg(3, 1, 0);
    cfg_idle_code = 3'd7;
    measure(1, 1, 1, 1, w);
    chk("R12", w, 4);

    // R2: every idle code with the method bit set
    for (int c = 0; c < 8; c++) begin
      write_cfg(c, 1, 0);
      measure(1, 0, 1, 1, w);
      chk("R2", w, dec_code(c));
    end

    // R3: method cleared, gap only on driver change
    write_cfg(2, 0, 0);
    measure(1, 1, 1, 0, w); chk("R3", w, 2);
    measure(1, 1, 1, 1, w); chk("R3", w, 0);
    measure(1, 0, 1, 0, w); chk("R3", w, 0);
    // R4: method set, same driver still waits
    write_cfg(5, 1, 0);
    measure(1, 1, 1, 1, w); chk("R4", w, 8);
    // R5: not acknowledged or not single-address
    measure(0, 1, 1, 0, w); chk("R5", w, 0);
    measure(1, 1, 0, 0, w); chk("R5", w, 0);

    // R7..R9 burst gating, R11 pending and ordering
    for (int p = 0; p < 4; p++) begin
      write_cfg(0, 0, p);
      drive(0, 0, 0, 1, 0); step();
      ref_req = 1; mst_req = 1; step();
      ref_req = 0; mst_req = 0;
      drive(0, 0, 0, 1, 0);
      for (int i = 0; i < 3; i++) step();
      set_idle(); step(); step();
      drive(0, 0, 0, 1, 1); step();
      set_idle();
      for (int i = 0; i < 3; i++) step();
    end
    // R10: error stays after a legal code
    chk("R10", prio_err, 1);
    write_cfg(0, 0, 0);
    idle_cycles(2);
    chk("R10", prio_err, 1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      cfg_wr = ($urandom % 25) == 0;
      cfg_idle_code = 3'($urandom); cfg_idle_all = 1'($urandom); cfg_burst_prio = 2'($urandom % 3);
      acc_valid = ($urandom % 10) < 7;
      acc_dack = 1'($urandom); acc_ext_drv = 1'($urandom); acc_single = ($urandom % 4) != 0;
      acc_burst = ($urandom % 5) < 3; acc_last = ($urandom % 5) == 0;
      ref_req = ($urandom % 8) == 0; mst_req = ($urandom % 8) == 0;
      step();
    end

    // R10: only reset clears the flag
    do_reset();
    chk("R10", prio_err, 0);
    chk("R1", bus_strobe, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule